// File: doc/BRIEF.md
# Ring Detector and Melody Gate

This block sits in the on-hook part of a telephone controller. It takes a ring signal that has already been squared up by a Schmitt trigger. It then decides whether a genuine ringing current is arriving. The time between successive rising edges must fall inside a window that corresponds to a ring frequency of roughly 13 Hz to 70 Hz. An edge whose period lies outside that window cancels the qualification. So does a silence of 80 ms with no edge at all.

Once in-band ringing has lasted 75 ms without interruption, the ring-valid flag rises and the melody gate starts. The melody output is open-drain. The pin value is held low, and the output enable switches to sink current in a square wave. The square wave alternates every 25 ms between a 1250 Hz tone and a 1600 Hz tone, and both half-periods are divided down from the system clock. Lifting the handset, which drives the hook input high, silences the block at the next clock edge. While the handset stays lifted, ring activity is ignored.

All times are counted in ticks of about 1 ms, obtained by dividing the clock. Every limit is a parameter.

Top module: `ring_melody_ctrl`

## Requirements
- R1: While hook_i is high, ring_valid_o and melody_oe_o are low one clock after it is sampled high, and ring edges arriving while it stays high never make ring_valid_o rise.
- R2: A ring rising edge is in band when the time since the previous rising edge, in whole ticks, lies in PER_MIN_T..PER_MAX_T inclusive (15..76 ticks by default). A rising edge outside that band clears ring_valid_o and the qualification.
- R3: ring_valid_o rises QUAL_T ticks (75 by default) after the first in-band edge, provided no disqualifying event occurs in between. It is low before that point.
- R4: If no rising edge arrives for TIMEOUT_T ticks (80 by default), ring_valid_o and melody_oe_o fall.
- R5: melody_o is always 0 (open-drain: only the enable toggles). melody_oe_o is high only in a cycle that follows a cycle in which ring_valid_o was high.
- R6: After the melody starts, melody_oe_o is a square wave that begins with a drive-low (enable high) half. Each half lasts round(CLK_HZ/(2*TONE_A_HZ)) cycles for the first SWAP_T ticks (25 by default). Each half then lasts round(CLK_HZ/(2*TONE_B_HZ)) cycles for the next SWAP_T ticks, and so on alternately. Each tone segment restarts with a drive-low half.
- R7: After reset, ring_valid_o and melody_oe_o are low, and the period history is treated as expired, so the first edge is never in band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hook_i | input | 1 | High when the handset is lifted (off-hook) |
| ring_i | input | 1 | Schmitt-conditioned ring signal, asynchronous |
| melody_o | output | 1 | Open-drain pin value, always low |
| melody_oe_o | output | 1 | Output enable: high sinks the melody pin low |
| ring_valid_o | output | 1 | Qualified ringing present |

## Verification
The assertions check several invariants on every cycle:
- the hook input clears both outputs one edge later;
- the enable never rises without validity in the preceding cycle;
- an out-of-band edge drops validity;
- validity only rises from the armed state;
- the qualification and half-period counters stay within their limits.

Other behaviours span hundreds of cycles, and only the bench's scenarios can show them. These are the 75 ms qualification delay, the exact inclusive band edges of 14/15 and 76/77 ticks, the 80 ms silence timeout, and the half-period lengths and 25 ms swap order of the two tones.

// File: rtl/ring_pkg.sv
package ring_pkg;

  typedef enum logic {
    TONE_A = 1'b0,
    TONE_B = 1'b1
  } tone_e;

  // Rounded integer division, used to derive clock dividers.
  function automatic int unsigned rdiv(input int unsigned num, input int unsigned den);
    return (num + den / 2) / den;
  endfunction

endpackage

// File: rtl/ring_edge_sync.sv
module ring_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic rise_o
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q <= '0;
    else       sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/ring_period_qual.sv
module ring_period_qual #(
  parameter int TICK_DIV = 3580,
  parameter int PER_MIN  = 15,
  parameter int PER_MAX  = 76,
  parameter int TIMEOUT  = 80,
  parameter int QUAL     = 75
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic rise_i,
  output logic valid_o
);

  localparam int TW = $clog2(TICK_DIV + 1);
  localparam int SW = $clog2(TIMEOUT + 2);
  localparam int QW = $clog2(QUAL + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);
  localparam logic [SW-1:0] TMO_V     = SW'(TIMEOUT);
  localparam logic [SW-1:0] TMO_PRE   = SW'(TIMEOUT - 1);
  localparam logic [SW-1:0] MIN_V     = SW'(PER_MIN);
  localparam logic [SW-1:0] MAX_V     = SW'(PER_MAX);
  localparam logic [QW-1:0] QUAL_V    = QW'(QUAL);

  logic [TW-1:0] tick_q, tick_n;
  logic [SW-1:0] since_q, since_n, meas;
  logic [QW-1:0] qual_q, qual_n;
  logic          armed_q, armed_n, valid_q, valid_n;
  logic          tick, in_band, timeout_hit, kill, arm_start;

  assign tick    = (tick_q == TICK_LAST);
  // Elapsed ticks at this edge, including a tick landing in the same cycle.
  assign meas    = since_q + {{(SW-1){1'b0}}, tick};
  assign in_band = (meas >= MIN_V) && (meas <= MAX_V);

  always_comb begin
    tick_n      = rise_i ? '0 : (tick ? '0 : tick_q + 1'b1);
    since_n     = since_q;
    if (rise_i)                       since_n = '0;
    else if (tick && since_q != TMO_V) since_n = since_q + 1'b1;
    timeout_hit = !rise_i && tick && (since_q == TMO_PRE);
    kill        = (rise_i && !in_band) || timeout_hit;
    arm_start   = rise_i && in_band && !armed_q;
    armed_n     = armed_q;
    qual_n      = qual_q;
    valid_n     = valid_q;
    if (kill) begin
      armed_n = 1'b0;
      qual_n  = '0;
      valid_n = 1'b0;
    end else if (arm_start) begin
      armed_n = 1'b1;
      qual_n  = '0;
      valid_n = 1'b0;
    end else if (armed_q && tick && !valid_q) begin
      qual_n  = qual_q + 1'b1;
      valid_n = (qual_q + 1'b1 == QUAL_V);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      tick_q  <= '0;
      since_q <= TMO_V;
      qual_q  <= '0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      tick_q  <= tick_n;
      since_q <= since_n;
      qual_q  <= qual_n;
      armed_q <= armed_n;
      valid_q <= valid_n;
    end
  end

  assign valid_o = valid_q;

  // R3
  qual_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    qual_q <= QUAL_V);

  // R3
  valid_from_armed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(valid_q) |-> $past(armed_q));

  // R2
  out_of_band_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_i && !in_band) |=> !valid_q);

endmodule

// File: rtl/ring_tone_gen.sv
module ring_tone_gen
  import ring_pkg::*;
#(
  parameter int TICK_DIV = 3580,
  parameter int HALF_A   = 1432,
  parameter int HALF_B   = 1119,
  parameter int SWAP     = 25
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic drive_o
);

  localparam int HMAX = (HALF_A > HALF_B) ? HALF_A : HALF_B;
  localparam int HW   = $clog2(HMAX + 1);
  localparam int TW   = $clog2(TICK_DIV + 1);
  localparam int WW   = $clog2(SWAP + 1);
  localparam logic [HW-1:0] HA_V      = HW'(HALF_A);
  localparam logic [HW-1:0] HB_V      = HW'(HALF_B);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);
  localparam logic [WW-1:0] SWAP_LAST = WW'(SWAP - 1);

  tone_e         sel_q;
  logic [HW-1:0] half_q, cur_half;
  logic [TW-1:0] tick_q;
  logic [WW-1:0] swap_q;
  logic          phase_q, started_q, tick, swap_now;

  assign cur_half = (sel_q == TONE_A) ? HA_V : HB_V;
  assign tick     = (tick_q == TICK_LAST);
  assign swap_now = tick && (swap_q == SWAP_LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      sel_q     <= TONE_A;
      half_q    <= '0;
      tick_q    <= '0;
      swap_q    <= '0;
      phase_q   <= 1'b0;
      started_q <= 1'b0;
    end else if (!started_q) begin
      started_q <= 1'b1;
      phase_q   <= 1'b1;
      half_q    <= '0;
      tick_q    <= '0;
      swap_q    <= '0;
    end else begin
      tick_q <= tick ? '0 : tick_q + 1'b1;
      if (swap_now) begin
        sel_q   <= (sel_q == TONE_A) ? TONE_B : TONE_A;
        swap_q  <= '0;
        half_q  <= '0;
        phase_q <= 1'b1;
      end else begin
        if (tick) swap_q <= swap_q + 1'b1;
        if (half_q == cur_half - 1'b1) begin
          half_q  <= '0;
          phase_q <= ~phase_q;
        end else begin
          half_q <= half_q + 1'b1;
        end
      end
    end
  end

  assign drive_o = phase_q;

  // R6
  half_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    half_q < cur_half);

  // R6
  swap_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    swap_q <= SWAP_LAST);

endmodule

// File: rtl/ring_melody_ctrl.sv
module ring_melody_ctrl
  import ring_pkg::*;
#(
  parameter int CLK_HZ      = 3579545,
  parameter int TICK_HZ     = 1000,
  parameter int TONE_A_HZ   = 1250,
  parameter int TONE_B_HZ   = 1600,
  parameter int PER_MIN_T   = 15,
  parameter int PER_MAX_T   = 76,
  parameter int TIMEOUT_T   = 80,
  parameter int QUAL_T      = 75,
  parameter int SWAP_T      = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hook_i,
  input  logic ring_i,
  output logic melody_o,
  output logic melody_oe_o,
  output logic ring_valid_o
);

  localparam int TICK_DIV = int'(rdiv(CLK_HZ, TICK_HZ));
  localparam int HALF_A   = int'(rdiv(CLK_HZ, 2 * TONE_A_HZ));
  localparam int HALF_B   = int'(rdiv(CLK_HZ, 2 * TONE_B_HZ));

  logic rise, valid, tone_en, drive;

  ring_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (ring_i),
    .rise_o(rise)
  );

  ring_period_qual #(
    .TICK_DIV(TICK_DIV),
    .PER_MIN (PER_MIN_T),
    .PER_MAX (PER_MAX_T),
    .TIMEOUT (TIMEOUT_T),
    .QUAL    (QUAL_T)
  ) u_qual (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (hook_i),
    .rise_i (rise),
    .valid_o(valid)
  );

  assign tone_en = valid & ~hook_i;

  ring_tone_gen #(
    .TICK_DIV(TICK_DIV),
    .HALF_A  (HALF_A),
    .HALF_B  (HALF_B),
    .SWAP    (SWAP_T)
  ) u_tone (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (tone_en),
    .drive_o(drive)
  );

  assign melody_o     = 1'b0;
  assign melody_oe_o  = drive;
  assign ring_valid_o = valid;

  // R1
  offhook_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hook_i |=> (!ring_valid_o && !melody_oe_o));

  // R5
  oe_needs_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    melody_oe_o |-> $past(ring_valid_o));

endmodule

// File: tb/ring_melody_ctrl_test.sv
module ring_melody_ctrl_test;

  localparam int CYC = 8;   // cycles per tick with the bench parameters
  localparam int HA  = 4;   // tone A half period in cycles
  localparam int HB  = 8;   // tone B half period in cycles

  typedef struct {
    int    kind;  // 0 valid, 1 oe, 2 pin, 3 run length
    int    idx;
    int    exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hook = 1'b0;
  logic ring = 1'b0;
  logic mel, mel_oe, rvalid;

  item_t exp_q[$];
  int    vectors = 0;
  int    errors  = 0;
  int    run_len[0:127];
  int    run_cnt = 0;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  ring_melody_ctrl #(
    .CLK_HZ   (8000),
    .TICK_HZ  (1000),
    .TONE_A_HZ(1000),
    .TONE_B_HZ(500)
  ) uut (
    .clk_i       (clk),
    .rst_i       (rst),
    .hook_i      (hook),
    .ring_i      (ring),
    .melody_o    (mel),
    .melody_oe_o (mel_oe),
    .ring_valid_o(rvalid)
  );

  // Driver side: push an expectation and let the monitor consume it.
  task automatic expect_val(input int kind, input int idx, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  task automatic ring_pulses(input int per_ticks, input int n);
    for (int i = 0; i < n; i++) begin
      ring = 1'b1;
      repeat (per_ticks * CYC / 2) @(negedge clk);
      ring = 1'b0;
      repeat (per_ticks * CYC - per_ticks * CYC / 2) @(negedge clk);
    end
  endtask

  task automatic idle_ticks(input int t);
    ring = 1'b0;
    repeat (t * CYC) @(negedge clk);
  endtask

  // Monitor: pops expected items and compares with what the design shows.
  initial begin
    forever begin
      item_t it;
      int obs;
      wait (exp_q.size() != 0);
      it = exp_q[0];
      case (it.kind)
        0: obs = int'(rvalid);
        1: obs = int'(mel_oe);
        2: obs = int'(mel);
        default: obs = (it.idx < run_cnt) ? run_len[it.idx] : -1;
      endcase
      vectors++;
      if (obs != it.exp) begin
        errors++;
        $display("FAIL %s: actual=%0d expected=%0d", it.tag, obs, it.exp);
      end
      void'(exp_q.pop_front());
    end
  end

  // Records the run lengths of the melody enable during the first melody.
  initial begin
    bit   started = 1'b0;
    logic prev = 1'b0;
    int   cur = 0;
    forever begin
      @(negedge clk);
      if (!started) begin
        if (mel_oe === 1'b1) begin
          started = 1'b1;
          cur = 1;
        end
      end else if (run_cnt < 80) begin
        if (mel_oe == prev) cur++;
        else begin
          run_len[run_cnt] = cur;
          run_cnt++;
          cur = 1;
        end
      end
      prev = mel_oe;
    end
  end

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    expect_val(0, 0, 0, "R7 valid after reset");
    expect_val(1, 0, 0, "R7 oe after reset");
    expect_val(2, 0, 0, "R5 pin after reset");

    // R3 qualification delay with a 40 ms period
    ring_pulses(40, 2);
    expect_val(0, 0, 0, "R3 valid before 75 ms");
    expect_val(1, 0, 0, "R5 oe without valid");
    ring_pulses(40, 1);
    expect_val(0, 0, 1, "R3 valid after 75 ms");
    ring_pulses(40, 6);
    expect_val(2, 0, 0, "R5 pin during melody");
    expect_val(3, 0, HA, "R6 tone A run 0");
    expect_val(3, 1, HA, "R6 tone A run 1");
    expect_val(3, 2, HA, "R6 tone A run 2");
    expect_val(3, 50, HB, "R6 tone B run 50");
    expect_val(3, 51, HB, "R6 tone B run 51");
    expect_val(3, 75, HA, "R6 tone A again run 75");
    idle_ticks(90);
    expect_val(0, 0, 0, "R4 valid after silence");
    expect_val(1, 0, 0, "R4 oe after silence");

    // R2 band limits
    ring_pulses(14, 12);
    expect_val(0, 0, 0, "R2 period 14 rejected");
    idle_ticks(90);
    ring_pulses(15, 8);
    expect_val(0, 0, 1, "R2 period 15 accepted");
    idle_ticks(90);
    ring_pulses(77, 3);
    expect_val(0, 0, 0, "R2 period 77 rejected");
    idle_ticks(90);
    ring_pulses(76, 3);
    expect_val(0, 0, 1, "R2 period 76 accepted");
    idle_ticks(90);

    // R1 off-hook
    ring_pulses(40, 4);
    expect_val(0, 0, 1, "R1 valid before off-hook");
    hook = 1'b1;
    repeat (2) @(negedge clk);
    expect_val(0, 0, 0, "R1 valid off-hook");
    expect_val(1, 0, 0, "R1 oe off-hook");
    ring_pulses(40, 4);
    expect_val(0, 0, 0, "R1 ring ignored off-hook");
    expect_val(1, 0, 0, "R1 oe stays off off-hook");
    hook = 1'b0;
    idle_ticks(90);

    // R2 out-of-band edge while valid
    ring_pulses(40, 4);
    expect_val(0, 0, 1, "R2 valid before short edge");
    ring_pulses(10, 1);
    ring = 1'b1;
    repeat (5) @(negedge clk);
    expect_val(0, 0, 0, "R2 short edge drops valid");
    expect_val(1, 0, 0, "R2 short edge stops melody");
    ring = 1'b0;
    idle_ticks(10);

    done = 1'b1;
    report();
  end

endmodule